// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 64-bit integer datapath that treats its two operands as a set of equal-width lanes and applies a single operation to all lanes in the same cycle. A two-bit size input picks the lane width at run time. The lanes can be eight bytes, four 16-bit halves, two 32-bit words or one 64-bit value. A four-bit opcode picks one of these operations:

- add or subtract, either wrapping or clipped at the lane limits;
- a compare that writes a lane mask;
- a bitwise logic function;
- a shift by one scalar count that applies to every lane.

The result is captured in a register and appears one clock after the operands, together with a valid flag. Carries, borrows and shifted bits never cross a lane boundary. This lets an execution pipeline process pixel or audio samples several at a time.

Top module: `simd_alu`

## Requirements
- R1: The lane size code is 0 for 8-bit lanes, 1 for 16-bit lanes, 2 for 32-bit lanes and 3 for one 64-bit lane. Lane i occupies bits [i*W +: W]. Opcode 0 is a wrapping add and opcode 1 is a wrapping subtract (a minus b), each modulo 2^W per lane, and no carry or borrow reaches the next lane.
- R2: Opcodes 2 and 3 are the signed add and the signed subtract. At 8-bit lanes the result clips to [-128, 127], and at 16-bit lanes it clips to [-32768, 32767].
- R3: Opcodes 4 and 5 are the unsigned add and the unsigned subtract. At 8-bit lanes the result clips to [0, 255], and at 16-bit lanes it clips to [0, 65535].
- R4: When opcodes 2 to 5 are used at 32-bit or 64-bit lanes, they give the same wrapping result as opcodes 0 and 1.
- R5: Opcode 6 sets a lane to all ones when its two operand lanes are equal, and to all zeros when they differ.
- R6: Opcode 7 sets a lane to all ones when the a lane is greater than the b lane, both read as signed two's-complement values. Otherwise the lane is all zeros.
- R7: Opcodes 8, 9 and 10 give a AND b, a OR b and a XOR b over all 64 bits, whatever the lane size.
- R8: Opcode 11 shifts each lane left and opcode 12 shifts each lane right, both logically. The count is the 7-bit shift input and zeros fill the vacated bits. A count of W or more makes the lane zero.
- R9: Opcode 13 shifts each lane right arithmetically and fills with the lane's sign bit. A count of W or more fills the whole lane with its sign bit.
- R10: Output valid equals input valid one clock earlier. The result register loads only in a cycle with input valid high, and otherwise it holds its value. Reset clears both the result and output valid to zero.
- R11: Opcodes 14 and 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opcode | input | 4 | Operation select |
| lane_sz | input | 2 | Lane width select |
| shamt | input | 7 | Shift count shared by all lanes |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Registered packed result |

## Verification
The only state in this block is the result register and the valid flag, so an internal fault appears at the ports one clock after the operation that triggers it.

- A broken lane partition shows up as a wrong bit in the lane next to the real error. The bench uses operands that carry out of every lane to expose this.
- A wrong clipping limit or a wrong overflow test appears only when the operands land at the signed or unsigned limits. The sweep therefore pairs the extreme patterns with each other.
- An unwanted load of the register shows up as a changed result in the idle cycle that follows each transaction.

// File: rtl/simd_alu.sv
module simd_alu #(
  parameter int SAT_MAX_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [3:0]  opcode,
  input  logic [1:0]  lane_sz,
  input  logic [6:0]  shamt,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  output logic        out_valid,
  output logic [63:0] result
);
  localparam int DW = 64;
  localparam int NSZ = 4;

  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_ADDS = 4'd2, OP_SUBS = 4'd3,
                         OP_ADDU = 4'd4, OP_SUBU = 4'd5, OP_CEQ = 4'd6, OP_CGT = 4'd7,
                         OP_AND = 4'd8, OP_OR = 4'd9, OP_XOR = 4'd10, OP_SLL = 4'd11,
                         OP_SRL = 4'd12, OP_SRA = 4'd13;

  logic [DW-1:0] size_res [NSZ];

  for (genvar g = 0; g < NSZ; g++) begin : g_sz
    localparam int W = 8 << g;
    localparam int N = DW / W;
    localparam bit SAT = (W <= SAT_MAX_W);
    logic [DW-1:0] res;

    for (genvar l = 0; l < N; l++) begin : g_ln
      logic [W-1:0] a, b, r, clip;
      logic [W:0]   s, d;
      logic         sov, dov;

      assign a    = op_a[l*W +: W];
      assign b    = op_b[l*W +: W];
      assign s    = {1'b0, a} + {1'b0, b};
      assign d    = {1'b0, a} - {1'b0, b};
      assign sov  = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
      assign dov  = (a[W-1] != b[W-1]) && (d[W-1] != a[W-1]);
      assign clip = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};

      always_comb begin
        case (opcode)
          OP_ADD:  r = s[W-1:0];
          OP_SUB:  r = d[W-1:0];
          OP_ADDS: r = (SAT && sov) ? clip : s[W-1:0];
          OP_SUBS: r = (SAT && dov) ? clip : d[W-1:0];
          OP_ADDU: r = (SAT && s[W]) ? {W{1'b1}} : s[W-1:0];
          OP_SUBU: r = (SAT && d[W]) ? {W{1'b0}} : d[W-1:0];
          OP_CEQ:  r = {W{a == b}};
          OP_CGT:  r = {W{$signed(a) > $signed(b)}};
          OP_AND:  r = a & b;
          OP_OR:   r = a | b;
          OP_XOR:  r = a ^ b;
          OP_SLL:  r = a << shamt;
          OP_SRL:  r = a >> shamt;
          OP_SRA:  r = $signed(a) >>> shamt;
          default: r = '0;
        endcase
      end

      assign res[l*W +: W] = r;
    end

    assign size_res[g] = res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= size_res[lane_sz];
    end
  end

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
  a_r5_equal_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_CEQ && op_a == op_b) |=> (result == {DW{1'b1}}));
  a_r7_xor_self: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_XOR && op_a == op_b) |=> (result == '0));
  a_r3_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_SUBU && !lane_sz[1] && op_a == '0) |=> (result == '0));
  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[3:1] == 3'b111) |=> (result == '0));
endmodule

// File: tb/simd_alu_tb.sv
module simd_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PER_CASE = 40;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [3:0] opcode = '0;
  logic [1:0] lane_sz = '0;
  logic [6:0] shamt = '0;
  logic [63:0] op_a = '0, op_b = '0;
  logic out_valid;
  logic [63:0] result;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  simd_alu dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .lane_sz(lane_sz), .shamt(shamt), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string req_of(input logic [3:0] op, input logic [1:0] sz);
    case (op)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3: return sz[1] ? "R4" : "R2";
      4'd4, 4'd5: return sz[1] ? "R4" : "R3";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8, 4'd9, 4'd10: return "R7";
      4'd11, 4'd12: return "R8";
      4'd13: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [3:0] op, input logic [1:0] sz,
      input logic [6:0] cnt, input logic [63:0] a, input logic [63:0] b);
    int w = 8 << sz;
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [63:0] out = '0;
    for (int i = 0; i < 64 / w; i++) begin
      logic [63:0] ua = (a >> (i*w)) & mask;
      logic [63:0] ub = (b >> (i*w)) & mask;
      logic [63:0] r;
      longint sa = (w < 64 && ua[w-1]) ? longint'(ua | ~mask) : longint'(ua);
      longint sb = (w < 64 && ub[w-1]) ? longint'(ub | ~mask) : longint'(ub);
      longint lo = -(longint'(1) <<< (w-1));
      longint hi = (longint'(1) <<< (w-1)) - 1;
      bit sat = (w <= 16);
      case (op)
        4'd0: r = ua + ub;
        4'd1: r = ua - ub;
        4'd2: r = sat ? 64'(sa + sb > hi ? hi : (sa + sb < lo ? lo : sa + sb)) : ua + ub;
        4'd3: r = sat ? 64'(sa - sb > hi ? hi : (sa - sb < lo ? lo : sa - sb)) : ua - ub;
        4'd4: r = sat ? ((ua + ub > mask) ? mask : ua + ub) : ua + ub;
        4'd5: r = sat ? ((ua < ub) ? 64'd0 : ua - ub) : ua - ub;
        4'd6: r = (ua == ub) ? mask : 64'd0;
        4'd7: r = (sa > sb) ? mask : 64'd0;
        4'd8: r = ua & ub;
        4'd9: r = ua | ub;
        4'd10: r = ua ^ ub;
        4'd11: r = (int'(cnt) >= w) ? 64'd0 : (ua << cnt);
        4'd12: r = (int'(cnt) >= w) ? 64'd0 : (ua >> cnt);
        4'd13: r = (int'(cnt) >= w) ? ((sa < 0) ? mask : 64'd0) : 64'(sa >>> cnt);
        default: r = 64'd0;
      endcase
      out |= (r & mask) << (i*w);
    end
    return out;
  endfunction

  function automatic logic [63:0] pattern(input int k);
    case (k)
      0: return 64'h0000_0000_0000_0000;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h7F7F_7F7F_7F7F_7F7F;
      3: return 64'h8080_8080_8080_8080;
      4: return 64'h7FFF_7FFF_7FFF_7FFF;
      5: return 64'h8000_8000_8000_8000;
      6: return 64'h0101_0101_0101_0101;
      7: return 64'h7FFF_FFFF_8000_0000;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp,
      input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", {63'd0, out_valid}, 64'd0, "out_valid in reset");
    check("R10", result, 64'd0, "result in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {63'd0, out_valid}, 64'd0, "out_valid after reset");
    for (int op = 0; op < 16; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int k = 0; k < PER_CASE; k++) begin
          int w = 8 << sz;
          logic [63:0] a = pattern(k % 9 == 8 ? 8 : k % 8);
          logic [63:0] b = pattern(k < 8 ? (k * 3) % 8 : (k % 5 == 0 ? k % 8 : 8));
          logic [6:0] cnt;
          logic [63:0] exp, held;
          case (k % 8)
            0: cnt = 7'd0;
            1: cnt = 7'(w - 1);
            2: cnt = 7'(w);
            3: cnt = 7'(w + 1);
            4: cnt = 7'd127;
            default: cnt = 7'($urandom_range(0, w - 1));
          endcase
          if (k == 9) b = a;
          opcode = 4'(op); lane_sz = 2'(sz); shamt = cnt; op_a = a; op_b = b;
          in_valid = 1'b1;
          exp = model(4'(op), 2'(sz), cnt, a, b);
          @(negedge clk);
          check("R10", {63'd0, out_valid}, 64'd1, "valid one clock later");
          check(req_of(4'(op), 2'(sz)), result, exp, $sformatf("op %0d size %0d", op, sz));
          held = result;
          in_valid = 1'b0;
          op_a = ~a; op_b = {$urandom, $urandom}; opcode = 4'(op ^ 1);
          @(negedge clk);
          check("R10", {63'd0, out_valid}, 64'd0, "valid low when idle");
          check("R10", result, held, "result held when idle");
        end
      end
    end
    finish_run();
  end
endmodule